// File: doc/BRIEF.md
# Interrupt Request Capture and Retrigger Stage

This block is the front end of a small interrupt controller. Each of its request lines is brought into the clock domain through a short synchronizer. Each line then becomes a pending request, tracked per source together with an in-service flag. The in-service flag is set when the processor acknowledges the source and cleared when the matching end-of-interrupt command arrives. The block raises one interrupt output whenever any source is pending and not in service. It reports the lowest-numbered such source as the one the next acknowledge will take.

Every source has its own trigger-style bit.

- **Legacy style:** a rising line makes the source pending, and a falling line takes back a request that nobody has acknowledged yet. The source behaves like a level that cannot fire again until its line has dropped.
- **Edge style:** one edge per pulse is recorded, and a per-source polarity bit picks which edge that is. An active edge that arrives while the source is in service is kept as a fresh pending request. That request is signalled the cycle after the end-of-interrupt, so short pulses are not lost.

Top module: `irqc_capture_top`

## Requirements
- R1: After reset no source is pending or in service, `irq_out` is 0 and `irq_id` is 0.
- R2: In legacy style (`edge_mode[i]`=0), a rising edge on `req_in[i]` makes source i pending, which raises `irq_out` with `irq_id`=i.
- R3: In legacy style, a falling edge on a pending source that has not been acknowledged withdraws the request, and `irq_out` returns to 0.
- R4: In legacy style, a falling edge after the source has been acknowledged has no effect: no request reappears, either while the source is in service or after its end-of-interrupt.
- R5: In edge style with `fall_pol[i]`=0, only a rising edge makes the source pending; a falling edge is ignored.
- R6: In edge style with `fall_pol[i]`=1, only a falling edge makes the source pending; a rising edge is ignored.
- R7: An `ack` pulse moves the source named by `irq_id` from pending to in service. A source in service does not drive `irq_out`.
- R8: In edge style, an active edge that arrives while the source is in service is stored. `irq_out` rises at the first sampling point after the clock edge that takes the `eoi` pulse for that source.
- R9: Any number of active edges during one in-service period collapse into a single pending request.
- R10: When several sources are pending and not in service, `irq_id` names the lowest-numbered one.
- R11: An `ack` pulse while `irq_out` is 0 is ignored and puts no source in service.
- R12: `eoi` clears only the source named by `eoi_sel`; an `eoi` naming another source leaves the in-service source masked.
- R13: A change on `req_in` takes effect on the third rising clock edge after it: `irq_out` is still 0 after the second edge and is 1 after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NUM_SRC | Asynchronous request lines, one per source |
| edge_mode | input | NUM_SRC | Per-source trigger style: 0 legacy, 1 edge |
| fall_pol | input | NUM_SRC | Per-source active edge in edge style: 0 rising, 1 falling |
| ack | input | 1 | Acknowledge strobe, applies to the source on `irq_id` |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_sel | input | ID_W | Source that the end-of-interrupt strobe clears |
| irq_out | output | 1 | High while some source is pending and not in service |
| irq_id | output | ID_W | Lowest-numbered source that is pending and not in service |

## Verification
The bench goes after the retrigger window. It pulses a source while that source is in service and looks for the interrupt the cycle after end-of-interrupt; a design that drops the edge stays silent, and one that forgets to mask in-service sources fires too early. Several pulses in one window must produce one request, not two. Legacy withdrawal is tested both before and after acknowledge, since a design that mixes these up either keeps a stale request or brings back a serviced one. Polarity and the three-edge synchronizer latency are checked to the cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    TRIG_LEGACY = 1'b0,
    TRIG_EDGE   = 1'b1
  } trig_style_e;

  // Event that sets the pending bit for one source.
  function automatic logic set_event(input trig_style_e style, input logic pol_fall,
                                     input logic rise, input logic fall);
    logic active_edge;
    active_edge = pol_fall ? fall : rise;
    return (style == TRIG_EDGE) ? active_edge : rise;
  endfunction

  // Event that takes back an unacknowledged request (legacy only).
  function automatic logic drop_event(input trig_style_e style, input logic fall);
    return (style == TRIG_LEGACY) && fall;
  endfunction

  function automatic logic next_pending(input logic pend, input logic set_evt,
                                        input logic drop_evt, input logic ack_hit);
    return set_evt | (pend & ~ack_hit & ~drop_evt);
  endfunction

  function automatic logic next_in_service(input logic insvc, input logic ack_hit,
                                           input logic eoi_hit);
    return ack_hit | (insvc & ~eoi_hit);
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic style_edge,
  input  logic pol_fall,
  input  logic ack_hit,
  input  logic eoi_hit,
  output logic rise,
  output logic fall,
  output logic set_evt,
  output logic pend_q,
  output logic insvc_q
);

  logic        prev_q;
  logic        drop_evt;
  trig_style_e style;

  assign style = style_edge ? TRIG_EDGE : TRIG_LEGACY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_s;
  end

  assign rise     = line_s & ~prev_q;
  assign fall     = ~line_s & prev_q;
  assign set_evt  = set_event(style, pol_fall, rise, fall);
  assign drop_evt = drop_event(style, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      pend_q  <= next_pending(pend_q, set_evt, drop_evt, ack_hit);
      insvc_q <= next_in_service(insvc_q, ack_hit, eoi_hit);
    end
  end

endmodule

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic [N-1:0]    req_vec,
  output logic            any,
  output logic [ID_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) idx = ID_W'(i);
    end
  end

  assign any = |req_vec;

endmodule

// File: rtl/irqc_capture_top.sv
module irqc_capture_top #(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic [NUM_SRC-1:0] edge_mode,
  input  logic [NUM_SRC-1:0] fall_pol,
  input  logic               ack,
  input  logic               eoi,
  input  logic [ID_W-1:0]    eoi_sel,
  output logic               irq_out,
  output logic [ID_W-1:0]    irq_id
);

  logic [NUM_SRC-1:0] line_s;
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] fall_vec;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] insvc_q;
  logic [NUM_SRC-1:0] visible_vec;
  logic [NUM_SRC-1:0] ack_hit_vec;
  logic [NUM_SRC-1:0] eoi_hit_vec;

  irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (req_in),
    .sync_out (line_s)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign ack_hit_vec[i] = ack & irq_out & (irq_id == ID_W'(i));
      assign eoi_hit_vec[i] = eoi & (eoi_sel == ID_W'(i));

      irqc_src_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s     (line_s[i]),
        .style_edge (edge_mode[i]),
        .pol_fall   (fall_pol[i]),
        .ack_hit    (ack_hit_vec[i]),
        .eoi_hit    (eoi_hit_vec[i]),
        .rise       (rise_vec[i]),
        .fall       (fall_vec[i]),
        .set_evt    (set_vec[i]),
        .pend_q     (pend_q[i]),
        .insvc_q    (insvc_q[i])
      );
    end
  endgenerate

  assign visible_vec = pend_q & ~insvc_q;

  irqc_lowest #(.N(NUM_SRC), .ID_W(ID_W)) u_pick (
    .req_vec (visible_vec),
    .any     (irq_out),
    .idx     (irq_id)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_out,
  input logic [ID_W-1:0] irq_id,
  input logic [N-1:0]    edge_mode,
  input logic [N-1:0]    fall_pol,
  input logic [N-1:0]    rise_vec,
  input logic [N-1:0]    fall_vec,
  input logic [N-1:0]    pend_q,
  input logic [N-1:0]    insvc_q,
  input logic [N-1:0]    ack_hit_vec,
  input logic [N-1:0]    eoi_hit_vec
);

  logic [N-1:0] below_mask;
  always_comb begin
    for (int i = 0; i < N; i++) below_mask[i] = (i < int'(irq_id));
  end

  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_hit_vec) |=> ((insvc_q & $past(ack_hit_vec)) == $past(ack_hit_vec))); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit_vec)); // R7

  AST_RESIGNAL_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eoi_hit_vec & pend_q & insvc_q)) |=> irq_out); // R8

  AST_LEGACY_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fall_vec & ~edge_mode)) |=> ((pend_q & $past(fall_vec & ~edge_mode)) == '0)); // R3

  AST_FALLPOL_IGNORES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise_vec & edge_mode & fall_pol & ~pend_q))
      |=> ((pend_q & $past(rise_vec & edge_mode & fall_pol & ~pend_q)) == '0)); // R6

  AST_LOWEST_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (((pend_q & ~insvc_q & below_mask) == '0)
                 && pend_q[irq_id] && !insvc_q[irq_id])); // R10

endmodule

bind irqc_capture_top irqc_checker #(.N(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_out     (irq_out),
  .irq_id      (irq_id),
  .edge_mode   (edge_mode),
  .fall_pol    (fall_pol),
  .rise_vec    (rise_vec),
  .fall_vec    (fall_vec),
  .pend_q      (pend_q),
  .insvc_q     (insvc_q),
  .ack_hit_vec (ack_hit_vec),
  .eoi_hit_vec (eoi_hit_vec)
);

// File: tb/irqc_capture_top_tb.sv
`timescale 1ns/1ps
module irqc_capture_top_tb;

  localparam int N    = 4;
  localparam int ID_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_in = '0;
  logic [N-1:0]    edge_mode = '0;
  logic [N-1:0]    fall_pol = '0;
  logic            ack = 1'b0;
  logic            eoi = 1'b0;
  logic [ID_W-1:0] eoi_sel = '0;
  logic            irq_out;
  logic [ID_W-1:0] irq_id;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irqc_capture_top #(.NUM_SRC(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .edge_mode(edge_mode),
    .fall_pol(fall_pol), .ack(ack), .eoi(eoi), .eoi_sel(eoi_sel),
    .irq_out(irq_out), .irq_id(irq_id)
  );

  // {edge_mode, fall_pol, start level, end level, expected irq_out}
  localparam logic [4:0] VEC [6] = '{
    5'b00_01_1,  // legacy rise          R2
    5'b00_10_0,  // legacy fall after service R4
    5'b10_01_1,  // edge, rising pol, rise    R5
    5'b10_10_0,  // edge, rising pol, fall    R5
    5'b11_10_1,  // edge, falling pol, fall   R6
    5'b11_01_0   // edge, falling pol, rise   R6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_in = '0; ack = 1'b0; eoi = 1'b0; eoi_sel = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_eoi(input int src);
    @(negedge clk); eoi = 1'b1; eoi_sel = ID_W'(src);
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic pulse_line(input int src);
    @(negedge clk); req_in[src] = 1'b1;
    wait_n(2);
    req_in[src] = 1'b0;
    wait_n(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 irq_out", irq_out, 0);
    chk("R1 irq_id", irq_id, 0);

    // Table walk on source 0
    for (int v = 0; v < 6; v++) begin
      do_reset();
      edge_mode[0] = VEC[v][4];
      fall_pol[0]  = VEC[v][3];
      req_in[0]    = VEC[v][2];
      wait_n(5);
      if (irq_out) begin
        pulse_ack();
        pulse_eoi(0);
      end
      wait_n(1);
      req_in[0] = VEC[v][1];
      wait_n(5);
      chk(VEC[v][4] ? (VEC[v][3] ? "R6 table" : "R5 table")
                    : (VEC[v][0] ? "R2 table" : "R4 table"),
          irq_out, VEC[v][0]);
      if (VEC[v][0]) chk("R2 table irq_id", irq_id, 0);
    end

    // R13: synchronizer latency, edge style rising on source 0
    do_reset();
    edge_mode = '1; fall_pol = '0;
    @(negedge clk); req_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R13 after two edges", irq_out, 0);
    @(posedge clk); @(negedge clk);
    chk("R13 after third edge", irq_out, 1);

    // R3: legacy withdraw before ack
    do_reset();
    edge_mode = '0;
    req_in[2] = 1'b1; wait_n(4);
    chk("R2 raise src2", irq_out, 1);
    chk("R2 id src2", irq_id, 2);
    req_in[2] = 1'b0; wait_n(4);
    chk("R3 withdraw", irq_out, 0);

    // R4 / R7: legacy fall after ack does nothing
    do_reset();
    edge_mode = '0;
    req_in[1] = 1'b1; wait_n(4);
    pulse_ack();
    chk("R7 in service masks", irq_out, 0);
    req_in[1] = 1'b0; wait_n(4);
    chk("R4 fall while in service", irq_out, 0);
    pulse_eoi(1); wait_n(3);
    chk("R4 after eoi", irq_out, 0);

    // R10 / R7: two edge sources, lowest first
    do_reset();
    edge_mode = '1; fall_pol = '0;
    @(negedge clk); req_in[2] = 1'b1; req_in[1] = 1'b1;
    wait_n(4);
    chk("R10 lowest id", irq_id, 1);
    pulse_ack();
    chk("R7 next source", irq_out, 1);
    chk("R10 next id", irq_id, 2);
    pulse_ack();
    chk("R7 all in service", irq_out, 0);
    pulse_eoi(1); pulse_eoi(2); wait_n(2);
    chk("R5 level held no retrigger", irq_out, 0);

    // R8 / R12: edge during service, resignal after eoi
    do_reset();
    edge_mode = '1; fall_pol = '0;
    pulse_line(3);
    chk("R5 pulse captured", irq_out, 1);
    pulse_ack();
    pulse_line(3);
    chk("R8 masked during service", irq_out, 0);
    pulse_eoi(0); wait_n(1);
    chk("R12 eoi other source", irq_out, 0);
    @(negedge clk); eoi = 1'b1; eoi_sel = 2'd3;
    @(negedge clk); eoi = 1'b0;
    chk("R8 cycle after eoi", irq_out, 1);
    chk("R8 id", irq_id, 3);

    // R9: several edges during one service collapse
    pulse_ack();
    pulse_line(3); pulse_line(3); pulse_line(3);
    pulse_eoi(3); wait_n(1);
    chk("R9 one request", irq_out, 1);
    pulse_ack();
    pulse_eoi(3); wait_n(3);
    chk("R9 no second request", irq_out, 0);

    // R11: ack with nothing pending is ignored
    do_reset();
    edge_mode = '1; fall_pol = '0;
    pulse_ack();
    pulse_line(0);
    chk("R11 source not in service", irq_out, 1);
    chk("R11 id", irq_id, 0);

    summary();
    $finish;
  end

endmodule